// File: doc/BRIEF.md
# I2C Register-Access Slave

This block connects an I2C bus to a bank of byte-wide control registers that sit outside it. SCL and SDA are oversampled with a fast system clock. The block recognises start, repeated-start and stop conditions and checks the device address. The first byte of a write transfer loads an internal register pointer. Each data byte after it goes out on a parallel write port, and the pointer then steps by one.

Reads use the combined form. The host writes the address and the sub-address, issues a repeated start, and sends the read form of the address. The block then returns bytes starting at the pointer, most significant bit first, until the host answers a byte with NACK. The register contents come in through a parallel read port that is indexed by the pointer.

SDA is modelled as open drain. An output enable pulls the line low and otherwise leaves it released.

Top module: `i2c_reg_slave`

## Requirements
- R1: The address byte 0x40 (7-bit address 0x20, R/W bit 0) and 0x41 (R/W bit 1) are acknowledged: SDA is held low during the ninth SCL pulse. Every sub-address byte and every written data byte is acknowledged the same way.
- R2: In a write transfer, the byte after the address loads the pointer. The first data byte then gives exactly one `reg_wr_en` pulse, with `reg_wr_addr` equal to that sub-address and `reg_wdata` equal to the byte.
- R3: Each further data byte in the same transfer is written to the next address. The pointer wraps from 0xFF to 0x00, and once a write has finished `reg_rd_addr` shows the following address.
- R4: After a repeated start with address byte 0x41, the slave shifts out `reg_rdata` for the pointer, MSB first. Each bit is put on the line while SCL is low.
- R5: Each read byte advances the pointer. The slave goes on to the next byte while the host acknowledges (SDA low in the ninth pulse) and releases SDA for good after a NACK (SDA high).
- R6: An address byte with any other 7-bit address is not acknowledged. No write happens, and SDA stays released until the next start or stop.
- R7: The slave's SDA enable changes only while SCL is low.
- R8: While `rst_n` is low, asynchronously and without waiting for a clock, `sda_oe` is 0, `reg_wr_en` is 0 and the pointer is 0x00.
- R9: A stop or start that arrives partway through a data byte throws the partial byte away with no write. The pointer keeps its value.
- R10: A read with no sub-address phase (start, then 0x41) begins at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | PTR_W | Register address for the write |
| reg_wdata | output | 8 | Register write data |
| reg_rd_addr | output | PTR_W | Current register pointer; also the read index |
| reg_rdata | input | 8 | Register contents at `reg_rd_addr` |

## Verification
The bench drives the bus with these patterns:
- A single-byte write and a sequential write that crosses 0xFF. Together they separate sub-address loading from pointer stepping and wrap.
- A combined read ended by NACK and a read with no sub-address. These separate a pointer kept across transfers from one reloaded each time.
- A foreign address, a data byte cut off by a stop, and a reset applied while the slave drives its acknowledge. These show that nothing leaks into the register port.
- A 96-byte write across the wrap, read back in one transfer. This exposes any bit-order, off-by-one or prefetch error against arithmetic expected values.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } st_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else if (s == 0) stg[s] <= d;
            else stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_evdet.sv
module i2cs_evdet
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h20,
    parameter int         PTR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [PTR_W-1:0]  reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic [PTR_W-1:0]  ptr
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    st_e               st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              mack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            sh          <= '0;
            tx          <= '0;
            rw          <= 1'b0;
            mack        <= 1'b0;
            sda_oe      <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wdata   <= '0;
            ptr         <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (ev.scl_rise && cnt < FULL) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            if (st == ST_ADDR) begin
                                if (addr_hit(sh, DEV_ADDR)) begin
                                    rw     <= sh[0];
                                    sda_oe <= 1'b1;
                                    st     <= ST_ADDR_ACK;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end else if (st == ST_SUB) begin
                                ptr    <= sh[PTR_W-1:0];
                                sda_oe <= 1'b1;
                                st     <= ST_SUB_ACK;
                            end else begin
                                reg_wr_en   <= 1'b1;
                                reg_wr_addr <= ptr;
                                reg_wdata   <= sh;
                                ptr         <= ptr + 1'b1;
                                sda_oe      <= 1'b1;
                                st          <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                                st     <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_SUB;
                            end
                        end
                    end
                    ST_SUB_ACK, ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            st     <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_rise && cnt < FULL) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                st     <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[3'd7 - cnt[2:0]];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                tx     <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                                cnt    <= '0;
                                st     <= ST_RDATA;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK || st == ST_SUB_ACK || st == ST_WDATA_ACK) |-> sda_oe);

    // R2
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (ptr == PTR_W'(reg_wr_addr + 1'b1)));

    // R6
    ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);

    // R7
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(ev.scl));

    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!sda_oe && !reg_wr_en && ptr == '0);
        end
    end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h20,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [PTR_W-1:0]  reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic [PTR_W-1:0]  reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic [1:0] lines_s;
    bus_ev_t    ev;

    i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (lines_s)
    );

    i2cs_evdet u_evdet (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    i2cs_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .reg_rdata   (reg_rdata),
        .sda_oe      (sda_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wdata   (reg_wdata),
        .ptr         (reg_rd_addr)
    );
endmodule

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       init_go = 1'b0;
    logic       sda_oe, reg_wr_en;
    logic [7:0] reg_wr_addr, reg_wdata, reg_rd_addr, reg_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0] bank  [256];
    logic [7:0] exp_b [256];
    int         wr_seen = 0;
    int         r7_bad = 0;
    int         total = 0;
    int         fails = 0;
    logic       prev_oe = 1'b0;

    assign reg_rdata = bank[reg_rd_addr];

    i2c_reg_slave u_i2c_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (init_go) begin
            for (int i = 0; i < 256; i++) bank[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_wr_en) begin
            bank[reg_wr_addr] <= reg_wdata;
            wr_seen <= wr_seen + 1;
        end
        if (scl_m && rst_n && sda_oe != prev_oe) r7_bad <= r7_bad + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(10);
        sda_m = 1'b0; tick(10); scl_m = 1'b0;
    endtask

    task automatic bstop();
        tick(4); sda_m = 1'b0; tick(6); scl_m = 1'b1; tick(10);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        tick(4); sda_m = b; tick(6); scl_m = 1'b1; tick(5);
        seen = sda_line; tick(5); scl_m = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(v[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            v[i] = s;
        end
        bit_io(~mack, s);
    endtask

    logic       ack;
    logic [7:0] rd;
    int         w0;

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) exp_b[i] = 8'(i) ^ 8'h5A;
        init_go = 1'b1;
        tick(3);
        init_go = 1'b0;
        // R8: reset state
        chk(sda_oe == 1'b0 && reg_wr_en == 1'b0, "R8 reset outputs", {sda_oe, reg_wr_en}, 0);
        chk(reg_rd_addr == 8'h00, "R8 reset pointer", reg_rd_addr, 0);
        rst_n = 1'b1;
        tick(10);

        // R1 R2: single-byte write
        w0 = wr_seen;
        bstart();
        wbyte(8'h40, ack); chk(ack, "R1 write address ack", ack, 1);
        wbyte(8'h10, ack); chk(ack, "R1 sub-address ack", ack, 1);
        wbyte(8'h3C, ack); chk(ack, "R1 data ack", ack, 1);
        bstop();
        exp_b[8'h10] = 8'h3C;
        chk(wr_seen == w0 + 1, "R2 one write strobe", wr_seen - w0, 1);
        chk(bank[8'h10] == 8'h3C, "R2 data at sub-address", bank[8'h10], 8'h3C);

        // R3: sequential write with wrap
        w0 = wr_seen;
        bstart();
        wbyte(8'h40, ack);
        wbyte(8'hFE, ack);
        for (int i = 0; i < 4; i++) begin
            wbyte(8'(8'h11 * (i + 1)), ack);
            exp_b[8'(8'hFE + i)] = 8'(8'h11 * (i + 1));
        end
        bstop();
        chk(wr_seen == w0 + 4, "R3 write count", wr_seen - w0, 4);
        for (int i = 0; i < 4; i++)
            chk(bank[8'(8'hFE + i)] == exp_b[8'(8'hFE + i)], "R3 sequential wrap data",
                bank[8'(8'hFE + i)], exp_b[8'(8'hFE + i)]);
        chk(reg_rd_addr == 8'h02, "R3 pointer after wrap", reg_rd_addr, 8'h02);

        // R4 R5: combined read, ACK ACK NACK
        bstart();
        wbyte(8'h40, ack);
        wbyte(8'h10, ack);
        bstart();
        wbyte(8'h41, ack); chk(ack, "R1 read address ack", ack, 1);
        for (int i = 0; i < 3; i++) begin
            rbyte(i != 2, rd);
            chk(rd == exp_b[8'h10 + i], "R4 R5 combined read byte", rd, exp_b[8'h10 + i]);
        end
        tick(6);
        chk(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);
        bstop();
        chk(reg_rd_addr == 8'h13, "R5 pointer after read", reg_rd_addr, 8'h13);

        // R6: foreign address
        w0 = wr_seen;
        bstart();
        wbyte(8'h42, ack); chk(!ack, "R6 foreign address no ack", ack, 0);
        wbyte(8'h05, ack); chk(!ack, "R6 later byte no ack", ack, 0);
        wbyte(8'h99, ack); chk(!ack, "R6 later byte no ack", ack, 0);
        bstop();
        chk(wr_seen == w0, "R6 no write", wr_seen - w0, 0);
        chk(reg_rd_addr == 8'h13, "R6 pointer kept", reg_rd_addr, 8'h13);

        // R10: read without sub-address
        bstart();
        wbyte(8'h41, ack); chk(ack, "R10 direct read ack", ack, 1);
        rbyte(1'b1, rd); chk(rd == exp_b[8'h13], "R10 first byte at pointer", rd, exp_b[8'h13]);
        rbyte(1'b0, rd); chk(rd == exp_b[8'h14], "R10 second byte", rd, exp_b[8'h14]);
        bstop();

        // R9: stop in the middle of a data byte
        w0 = wr_seen;
        bstart();
        wbyte(8'h40, ack);
        wbyte(8'h30, ack);
        for (int i = 0; i < 4; i++) bit_io(1'b1, ack);
        bstop();
        chk(wr_seen == w0, "R9 partial byte dropped", wr_seen - w0, 0);
        chk(reg_rd_addr == 8'h30, "R9 pointer kept", reg_rd_addr, 8'h30);

        // R8: asynchronous reset while the slave is acknowledging
        bstart();
        for (int i = 7; i >= 0; i--) bit_io(logic'(8'h40 >> i), ack);
        tick(8);
        chk(sda_oe == 1'b1, "R1 ack being driven", sda_oe, 1);
        #3 rst_n = 1'b0;
        #2;
        chk(sda_oe == 1'b0, "R8 async release", sda_oe, 0);
        chk(reg_rd_addr == 8'h00, "R8 async pointer clear", reg_rd_addr, 0);
        sda_m = 1'b1;
        tick(2);
        scl_m = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(10);

        // R2 R3 R4 R5: long sweep across the wrap
        w0 = wr_seen;
        bstart();
        wbyte(8'h40, ack);
        wbyte(8'hC0, ack);
        for (int i = 0; i < 96; i++) begin
            wbyte(8'(i * 7 + 3), ack);
            exp_b[8'(8'hC0 + i)] = 8'(i * 7 + 3);
            chk(ack, "R1 sweep data ack", ack, 1);
        end
        bstop();
        chk(wr_seen == w0 + 96, "R3 sweep write count", wr_seen - w0, 96);
        bstart();
        wbyte(8'h40, ack);
        wbyte(8'hC0, ack);
        bstart();
        wbyte(8'h41, ack);
        for (int i = 0; i < 96; i++) begin
            rbyte(i != 95, rd);
            chk(rd == exp_b[8'(8'hC0 + i)], "R4 sweep read byte", rd, exp_b[8'(8'hC0 + i)]);
        end
        bstop();
        chk(reg_rd_addr == 8'h20, "R5 sweep pointer", reg_rd_addr, 8'h20);

        chk(r7_bad == 0, "R7 enable changes with SCL high", r7_bad, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule